// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates a set of sum-of-products functions on an input bus. Product terms are ANDs of selected input literals. Each output is an OR of selected product terms. The connections are held in configuration bits that are loaded through a serial shift chain. Two elaboration switches decide whether each plane is configurable or hard-wired, so one design yields three array styles:

- **Both planes configurable.**
- **Configurable AND plane with a hard-wired OR plane.** Each output sums its own private group of `N_TERM/N_OUT` terms.
- **Hard-wired AND plane with a configurable OR plane.** The AND plane is a full decoder that yields every minterm of the inputs, so `N_TERM` must equal `2**N_IN`. The block then behaves as a small lookup memory.

Configuration is shifted in one bit per clock while the load enable is high. Once loading ends, the outputs follow the inputs combinationally.

Top module: `sop_logic_array`

## Requirements
- R1: While `load_en_i` is high, every rising clock edge shifts `sdi_i` into the chain, MSB first. After W edges, the first bit sent sits at chain bit W-1.
  - The chain length is W = AW + OW.
  - AW = `N_TERM*2*N_IN` when the AND plane is configurable, else 0.
  - OW = `N_OUT*N_TERM` when the OR plane is configurable, else 0.
- R2: While `load_en_i` is low, the chain keeps its contents across clock edges, whatever `sdi_i` does.
- R3: While `load_en_i` is high, `out_o` is all zeros.
- R4: `rst_ni` low asynchronously clears every chain bit. After reset:
  - the both-configurable style and the decoder style output 0;
  - the hard-wired-OR style outputs all ones, because every term is then empty.
- R5: For a configurable AND plane, chain bit `t*2*N_IN+2*i` connects the true literal of input i to term t, and bit `t*2*N_IN+2*i+1` connects the complemented literal.
  - A literal with neither bit set is left out of the term.
  - A literal with both bits set forces the term to 0.
- R6: A product term with no literal connected evaluates to 1, so an output can be made constant 1.
- R7: For a configurable OR plane, chain bit `AW+o*N_TERM+t` connects term t to output o. An output with no term connected is constant 0.
- R8: With a hard-wired OR plane, output o is the OR of terms `o*J` through `o*J+J-1`, where J = `N_TERM/N_OUT`.
- R9: With a hard-wired AND plane, term t is 1 exactly when `in_i` equals t, and exactly one term is 1.
- R10: Outside loading, `out_o` responds to a change on `in_i` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Configuration shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the chain |
| load_en_i | input | 1 | Shift enable; also blanks the outputs |
| sdi_i | input | 1 | Serial configuration data, MSB first |
| in_i | input | N_IN | Logic inputs |
| out_o | output | N_OUT | Sum-of-products outputs |

## Verification
Any wrong chain bit shows at the ports only on the input pattern that the misplaced literal or OR link governs. So after each load, every output is compared against a model over all 2^N_IN input patterns. A shift or ordering fault is then caught on the first exhaustive sweep after the load that exposes it. A hold fault appears after a single idle clock with `sdi_i` toggling. Blanking and literal-encoding faults show immediately, on the same input pattern.

// File: rtl/sop_pkg.sv
package sop_pkg;
  function automatic int and_bits(int n_in, int n_term, bit prog);
    return prog ? n_term * 2 * n_in : 0;
  endfunction
  function automatic int or_bits(int n_term, int n_out, bit prog);
    return prog ? n_out * n_term : 0;
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_en_i,
  input  logic         sdi_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (load_en_i) begin
      if (W > 1) sr_q <= {sr_q[W-2:0], sdi_i};
      else       sr_q <= {W{sdi_i}};
    end
  end

  assign cfg_o = sr_q;

  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> cfg_o[0] == $past(sdi_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> $stable(cfg_o));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter bit PROG   = 1'b1,
  localparam int CW    = PROG ? N_TERM * 2 * N_IN : 1
) (
  input  logic [CW-1:0]     cfg_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_TERM-1:0] term_o
);
  if (PROG) begin : g_prog
    always_comb begin
      for (int t = 0; t < N_TERM; t++) begin
        term_o[t] = 1'b1;  // empty term is 1
        for (int i = 0; i < N_IN; i++) begin
          if (cfg_i[t*2*N_IN + 2*i]     && !in_i[i]) term_o[t] = 1'b0;
          if (cfg_i[t*2*N_IN + 2*i + 1] &&  in_i[i]) term_o[t] = 1'b0;
        end
      end
    end
  end else begin : g_decoder
    logic unused_cfg;
    assign unused_cfg = ^cfg_i;
    for (genvar t = 0; t < N_TERM; t++) begin : g_min
      assign term_o[t] = (in_i == N_IN'(t));
    end
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  parameter bit PROG   = 1'b1,
  localparam int CW    = PROG ? N_OUT * N_TERM : 1,
  localparam int J     = N_TERM / N_OUT
) (
  input  logic [CW-1:0]     cfg_i,
  input  logic [N_TERM-1:0] term_i,
  output logic [N_OUT-1:0]  out_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    if (PROG) begin : g_prog
      assign out_o[o] = |(term_i & cfg_i[o*N_TERM +: N_TERM]);
    end else begin : g_fixed
      assign out_o[o] = |term_i[o*J +: J];
    end
  end
  if (!PROG) begin : g_unused
    logic unused_cfg;
    assign unused_cfg = ^cfg_i;
  end
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_TERM   = 8,
  parameter int N_OUT    = 3,
  parameter bit AND_PROG = 1'b1,
  parameter bit OR_PROG  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             sdi_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o
);
  localparam int AW  = and_bits(N_IN, N_TERM, AND_PROG);
  localparam int OW  = or_bits(N_TERM, N_OUT, OR_PROG);
  localparam int W   = (AW + OW) > 0 ? AW + OW : 1;
  localparam int ACW = AND_PROG ? AW : 1;
  localparam int OCW = OR_PROG ? OW : 1;

  logic [W-1:0]      cfg;
  logic [ACW-1:0]    and_cfg;
  logic [OCW-1:0]    or_cfg;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sum;

  sop_cfg_chain #(.W(W)) u_chain (
    .clk_i, .rst_ni, .load_en_i, .sdi_i, .cfg_o(cfg)
  );

  if (AND_PROG) begin : g_and_cfg
    assign and_cfg = cfg[0 +: ACW];
  end else begin : g_and_none
    assign and_cfg = '0;
  end
  if (OR_PROG) begin : g_or_cfg
    assign or_cfg = cfg[AW +: OCW];
  end else begin : g_or_none
    assign or_cfg = '0;
  end

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .PROG(AND_PROG)) u_and (
    .cfg_i(and_cfg), .in_i, .term_o(term)
  );
  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .PROG(OR_PROG)) u_or (
    .cfg_i(or_cfg), .term_i(term), .out_o(sum)
  );

  assign out_o = load_en_i ? '0 : sum;

  a_r3_blank_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |-> out_o == '0);
  if (!AND_PROG) begin : g_chk_dec
    a_r9_one_minterm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(term) == 1);
  end
endmodule

// File: tb/sop_logic_array_test.sv
`timescale 1ns/1ps
module sop_logic_array_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] le = '0;
  logic [2:0] sd = '0;
  logic [3:0] in_f = '0, in_p = '0;
  logic [2:0] in_r = '0;
  logic [2:0] out_f;
  logic [3:0] out_p, out_r;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sop_logic_array #(.N_IN(4), .N_TERM(8), .N_OUT(3), .AND_PROG(1), .OR_PROG(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(le[0]), .sdi_i(sd[0]), .in_i(in_f), .out_o(out_f));
  sop_logic_array #(.N_IN(4), .N_TERM(8), .N_OUT(4), .AND_PROG(1), .OR_PROG(0)) uut_pal (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(le[1]), .sdi_i(sd[1]), .in_i(in_p), .out_o(out_p));
  sop_logic_array #(.N_IN(3), .N_TERM(8), .N_OUT(4), .AND_PROG(0), .OR_PROG(1)) uut_rom (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(le[2]), .sdi_i(sd[2]), .in_i(in_r), .out_o(out_r));

  int ni[3] = '{4, 4, 3};
  int np[3] = '{8, 8, 8};
  int no[3] = '{3, 4, 4};
  bit ap[3] = '{1, 1, 0};
  bit op[3] = '{1, 0, 1};
  logic [127:0] cur [3];

  function automatic int width(int k);
    return (ap[k] ? np[k]*2*ni[k] : 0) + (op[k] ? no[k]*np[k] : 0);
  endfunction

  function automatic logic [7:0] model(int k, logic [127:0] c, logic [7:0] x);
    logic [7:0] r = '0;
    logic [15:0] tm = '0;
    int aw = ap[k] ? np[k]*2*ni[k] : 0;
    int j = np[k] / no[k];
    for (int p = 0; p < np[k]; p++) begin
      if (ap[k]) begin
        tm[p] = 1'b1;
        for (int i = 0; i < ni[k]; i++) begin
          if (c[p*2*ni[k]+2*i] && x[i] == 1'b0) tm[p] = 1'b0;
          if (c[p*2*ni[k]+2*i+1] && x[i] == 1'b1) tm[p] = 1'b0;
        end
      end else tm[p] = (int'(x) == p);
    end
    for (int o = 0; o < no[k]; o++)
      for (int p = 0; p < np[k]; p++)
        if (op[k] ? (tm[p] && c[aw+o*np[k]+p]) : (tm[p] && p/j == o)) r[o] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] got(int k);
    case (k)
      0: return {5'd0, out_f};
      1: return {4'd0, out_p};
      default: return {4'd0, out_r};
    endcase
  endfunction

  task automatic set_in(int k, logic [7:0] x);
    case (k)
      0: in_f = x[3:0];
      1: in_p = x[3:0];
      default: in_r = x[2:0];
    endcase
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // R1 R3: shift MSB first, outputs blanked mid-load
  task automatic load(int k, logic [127:0] v);
    int w = width(k);
    @(negedge clk);
    le[k] = 1'b1;
    for (int b = w-1; b >= 0; b--) begin
      sd[k] = v[b];
      if (b == w/2) begin
        set_in(k, 8'hff);
        #0.5 check("R3 blank during load", got(k), 8'h00);
      end
      @(negedge clk);
    end
    le[k] = 1'b0;
    cur[k] = v;
  endtask

  task automatic sweep(int k, string req);
    for (int x = 0; x < (1 << ni[k]); x++) begin
      set_in(k, 8'(x));
      #0.5 check(req, got(k), model(k, cur[k], 8'(x)));
    end
  endtask

  function automatic logic [127:0] rnd_cfg();
    logic [127:0] v;
    v = {$urandom, $urandom, $urandom, $urandom};
    for (int b = 0; b < 64; b += 2)  // thin out double literals
      if (v[b] && v[b+1] && ($urandom % 4 != 0)) v[b+1] = 1'b0;
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] v;
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) cur[k] = '0;
    #12 rst_n = 1'b1;
    #1;
    // R4 reset state
    in_f = 4'h5; in_p = 4'h5; in_r = 3'h5;
    #0.5;
    check("R4 reset full", got(0), 8'h00);
    check("R4 reset pal", got(1), 8'h0f);
    check("R4 reset rom", got(2), 8'h00);

    // R5 R6 R7: directed full-style config
    v = '0;
    v[64 + 0*8 + 0] = 1'b1;                  // out0 <- term0 (empty) => const 1 (R6)
    v[1*8 + 2*0] = 1'b1; v[1*8 + 2*0 + 1] = 1'b1; // term1: both literals of in0 (R5)
    v[64 + 1*8 + 1] = 1'b1;                  // out1 <- term1 => const 0
    v[2*8 + 2*2] = 1'b1;                     // term2 = in2 true only (R5 omit others)
    v[2*8 + 2*3 + 1] = 1'b1;                 // and !in3
    v[64 + 2*8 + 2] = 1'b1;                  // out2 <- term2
    load(0, v);
    for (int x = 0; x < 16; x++) begin
      set_in(0, 8'(x));
      #0.5;
      check("R6 empty term const 1", {7'd0, got(0)[0]}, 8'h01);
      check("R5 both literals zero", {7'd0, got(0)[1]}, 8'h00);
      check("R5 literal select", {7'd0, got(0)[2]}, {7'd0, x[2] & ~x[3]});
    end

    // R7 no OR link => 0
    load(0, '0);
    sweep(0, "R7 unconnected output");

    // R1 R7 R8 R9 random loads, exhaustive sweeps
    for (int n = 0; n < 6; n++) begin
      load(0, rnd_cfg()); sweep(0, "R1 R7 full style");
      load(1, rnd_cfg()); sweep(1, "R1 R8 fixed OR style");
      load(2, {$urandom, $urandom, $urandom, $urandom}); sweep(2, "R1 R9 decoder style");
    end

    // R9 directed: only minterm 5 to out3
    v = '0; v[3*8 + 5] = 1'b1;
    load(2, v);
    for (int x = 0; x < 8; x++) begin
      set_in(2, 8'(x));
      #0.5 check("R9 single minterm", got(2), (x == 5) ? 8'h08 : 8'h00);
    end

    // R2 hold: clocks with load low and sdi toggling
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      sd = 3'($urandom);
    end
    for (int k = 0; k < 3; k++) sweep(k, "R2 hold when idle");

    // R10 combinational response between clock edges
    @(posedge clk);
    #1;
    for (int x = 0; x < 16; x++) begin
      in_p = 4'(x);
      #0.2 check("R10 combinational", got(1), model(1, cur[1], 8'(x)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule